// File: doc/BRIEF.md
# HI/LO multiply-divide unit

This block performs 32-bit signed and unsigned multiplication and division for a processor core and keeps the results in a pair of result registers, HI and LO. A multiply leaves the upper half of the 64-bit product in HI and the lower half in LO. A divide leaves the quotient in LO and the remainder in HI. The core can also load either register directly from a register value, and it reads both registers from the output ports.

A multiply finishes in a single cycle. A divide runs a restoring shift-subtract loop that produces one quotient bit per cycle. While it runs, `busy` stays high. The core must hold off any read of HI or LO, and it must issue no new operation, until `busy` falls. Operations presented while `busy` is high are dropped.

Top module: `muldiv_unit`

## Requirements
- R1: After reset `hi_q` and `lo_q` are zero and `busy` is low.
- R2: With `op_code` 1 (signed multiply) accepted at a clock edge, that same edge loads `hi_q` with bits 63:32 and `lo_q` with bits 31:0 of the two's-complement product of `src_a` and `src_b`. `busy` stays low.
- R3: With `op_code` 2 (unsigned multiply) accepted at a clock edge, that same edge loads `hi_q:lo_q` with the full 64-bit unsigned product of `src_a` and `src_b`.
- R4: With `op_code` 4 (unsigned divide), `lo_q` receives `src_a / src_b` and `hi_q` receives `src_a % src_b`. For a zero divisor, `lo_q` becomes all ones and `hi_q` becomes `src_a`.
- R5: With `op_code` 3 (signed divide) and a nonzero divisor, `lo_q` receives the quotient rounded toward zero, which is negative when the operand signs differ. `hi_q` receives the remainder, which carries the sign of the dividend. Dividing 0x80000000 by -1 yields 0x80000000 in `lo_q` and 0 in `hi_q`.
- R6: An accepted divide raises `busy` after its accepting edge and keeps it high for exactly WIDTH cycles. HI and LO are written at the edge where `busy` falls.
- R7: While `busy` is high, `op_valid` is ignored, and `hi_q` and `lo_q` hold their values until the divide writes them.
- R8: `op_code` 5 copies `src_a` into `hi_q`, and `op_code` 6 copies `src_a` into `lo_q`. The other register is left as it was. A later multiply or divide overwrites a value loaded this way.
- R9: An accepted `op_code` of 0 or 7 leaves `hi_q`, `lo_q` and `busy` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation request, taken when busy is low |
| op_code | input | 3 | 0 none, 1 signed mul, 2 unsigned mul, 3 signed div, 4 unsigned div, 5 load HI, 6 load LO |
| src_a | input | WIDTH | First operand, dividend or move source |
| src_b | input | WIDTH | Second operand or divisor |
| busy | output | 1 | Divide in progress |
| hi_q | output | WIDTH | HI register |
| lo_q | output | WIDTH | LO register |

## Verification
Multiplies, moves and no-operation codes take effect at the accepting edge, so the bench checks them at the falling edge that follows. For a divide, the bench counts the falling edges that see `busy` high and requires the count to be exactly 32. It reads HI and LO only at the first falling edge after `busy` drops. During a divide, the bench issues a move and confirms at the next falling edge that neither register has changed. Every pair drawn from a set of corner operands goes through all four arithmetic operations, and the bench compares each result against 64-bit arithmetic.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [2:0] {
    MD_NONE  = 3'd0,
    MD_MULS  = 3'd1,
    MD_MULU  = 3'd2,
    MD_DIVS  = 3'd3,
    MD_DIVU  = 3'd4,
    MD_LDHI  = 3'd5,
    MD_LDLO  = 3'd6
  } md_op_e;
endpackage

// File: rtl/muldiv_mult.sv
module muldiv_mult #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0]   opa,
  input  logic [WIDTH-1:0]   opb,
  input  logic               is_signed,
  output logic [2*WIDTH-1:0] prod
);
  localparam int PW = 2 * WIDTH;

  logic [PW-1:0] ext_a;
  logic [PW-1:0] ext_b;

  always_comb begin
    ext_a = {{WIDTH{is_signed & opa[WIDTH-1]}}, opa};
    ext_b = {{WIDTH{is_signed & opb[WIDTH-1]}}, opb};
    prod  = ext_a * ext_b;
  end
endmodule

// File: rtl/muldiv_div.sv
module muldiv_div #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             is_signed,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             active,
  output logic             done,
  output logic [WIDTH-1:0] quo_out,
  output logic [WIDTH-1:0] rem_out
);
  localparam int CW = $clog2(WIDTH + 1);

  logic [WIDTH-1:0] rem_q, rem_d, quo_q, quo_d, dvs_q, dvs_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             act_q, act_d, negq_q, negq_d, negr_q, negr_d;
  logic [WIDTH:0]   shifted, trial;
  logic [WIDTH-1:0] step_rem, step_quo, mag_a, mag_b;
  logic             sign_a, sign_b;

  always_comb begin
    sign_a   = is_signed & dividend[WIDTH-1];
    sign_b   = is_signed & divisor[WIDTH-1];
    mag_a    = sign_a ? (~dividend + 1'b1) : dividend;
    mag_b    = sign_b ? (~divisor + 1'b1) : divisor;
    shifted  = {rem_q, quo_q[WIDTH-1]};
    trial    = shifted - {1'b0, dvs_q};
    if (!trial[WIDTH]) begin
      step_rem = trial[WIDTH-1:0];
      step_quo = {quo_q[WIDTH-2:0], 1'b1};
    end else begin
      step_rem = shifted[WIDTH-1:0];
      step_quo = {quo_q[WIDTH-2:0], 1'b0};
    end
    done    = act_q && (cnt_q == CW'(1));
    quo_out = negq_q ? (~step_quo + 1'b1) : step_quo;
    rem_out = negr_q ? (~step_rem + 1'b1) : step_rem;
    active  = act_q;
  end

  always_comb begin
    rem_d  = rem_q;
    quo_d  = quo_q;
    dvs_d  = dvs_q;
    cnt_d  = cnt_q;
    act_d  = act_q;
    negq_d = negq_q;
    negr_d = negr_q;
    if (start) begin
      rem_d  = '0;
      quo_d  = mag_a;
      dvs_d  = mag_b;
      cnt_d  = CW'(WIDTH);
      act_d  = 1'b1;
      negq_d = sign_a ^ sign_b;
      negr_d = sign_a;
    end else if (act_q) begin
      rem_d = step_rem;
      quo_d = step_quo;
      cnt_d = cnt_q - 1'b1;
      act_d = !done;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      act_q  <= 1'b0;
      negq_q <= 1'b0;
      negr_q <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      quo_q  <= quo_d;
      dvs_q  <= dvs_d;
      cnt_q  <= cnt_d;
      act_q  <= act_d;
      negq_q <= negq_d;
      negr_q <= negr_d;
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (cnt_q != '0 && cnt_q <= CW'(WIDTH))); // R6
  AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !act_q); // R6
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> !start); // R7
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [2:0]       op_code,
  input  logic [WIDTH-1:0] src_a,
  input  logic [WIDTH-1:0] src_b,
  output logic             busy,
  output logic [WIDTH-1:0] hi_q,
  output logic [WIDTH-1:0] lo_q
);
  localparam int PW = 2 * WIDTH;

  logic             accept, is_mul, is_div, op_signed;
  logic             div_active, div_done;
  logic [PW-1:0]    product;
  logic [WIDTH-1:0] div_quo, div_rem;
  logic [WIDTH-1:0] hi_d, lo_d;
  logic             hi_en, lo_en;

  always_comb begin
    accept    = op_valid && !div_active;
    is_mul    = (op_code == MD_MULS) || (op_code == MD_MULU);
    is_div    = (op_code == MD_DIVS) || (op_code == MD_DIVU);
    op_signed = (op_code == MD_MULS) || (op_code == MD_DIVS);
  end

  muldiv_mult #(.WIDTH(WIDTH)) u_mult (
    .opa(src_a), .opb(src_b), .is_signed(op_signed), .prod(product)
  );

  muldiv_div #(.WIDTH(WIDTH)) u_div (
    .clk(clk), .rst_n(rst_n), .start(accept && is_div), .is_signed(op_signed),
    .dividend(src_a), .divisor(src_b), .active(div_active), .done(div_done),
    .quo_out(div_quo), .rem_out(div_rem)
  );

  always_comb begin
    hi_d  = hi_q;
    lo_d  = lo_q;
    hi_en = 1'b0;
    lo_en = 1'b0;
    if (div_done) begin
      hi_d  = div_rem;
      lo_d  = div_quo;
      hi_en = 1'b1;
      lo_en = 1'b1;
    end else if (accept && is_mul) begin
      hi_d  = product[PW-1:WIDTH];
      lo_d  = product[WIDTH-1:0];
      hi_en = 1'b1;
      lo_en = 1'b1;
    end else if (accept && op_code == MD_LDHI) begin
      hi_d  = src_a;
      hi_en = 1'b1;
    end else if (accept && op_code == MD_LDLO) begin
      lo_d  = src_a;
      lo_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      if (hi_en) hi_q <= hi_d;
      if (lo_en) lo_q <= lo_d;
    end
  end

  assign busy = div_active;

  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !div_done) |=> ($stable(hi_q) && $stable(lo_q))); // R7
  AST_MUL_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !busy && is_mul) |=> !busy); // R2
  AST_DIV_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !busy && is_div) |=> busy); // R6
  AST_IDLE_CODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !busy && (op_code == 3'd0 || op_code == 3'd7)) |=>
      ($stable(hi_q) && $stable(lo_q))); // R9
endmodule

// File: tb/muldiv_unit_tb.sv
module muldiv_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  op_code = 3'd0;
  logic [31:0] src_a = '0;
  logic [31:0] src_b = '0;
  logic        busy;
  logic [31:0] hi_q, lo_q;
  int          errors = 0;
  int          checks = 0;
  bit          finished = 1'b0;

  always #4 clk = ~clk;

  muldiv_unit #(.WIDTH(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .src_a(src_a), .src_b(src_b), .busy(busy), .hi_q(hi_q), .lo_q(lo_q)
  );

  function automatic logic [31:0] pick(input int i);
    case (i)
      0: return 32'h0000_0000;   1: return 32'h0000_0001;
      2: return 32'hFFFF_FFFF;   3: return 32'h8000_0000;
      4: return 32'h7FFF_FFFF;   5: return 32'h0000_0004;
      6: return 32'hFFFE_FFF0;   7: return 32'hFFFF_FFF0;
      8: return 32'h0000_000A;   9: return 32'h0000_0005;
      10: return 32'hFFFF_FFFB;  11: return 32'h000B_0000;
      12: return 32'h0005_0000;  13: return 32'h0000_0FFF;
      14: return 32'h1234_5678;  default: return 32'hFFFF_8000;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] code, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    op_valid = 1'b1; op_code = code; src_a = a; src_b = b;
    @(negedge clk);
    op_valid = 1'b0; op_code = 3'd0;
  endtask

  task automatic wait_div(input string req);
    int n = 0;
    while (busy && n < 100) begin
      n++;
      @(negedge clk);
    end
    check(req, 32'(n), 32'd32);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 hi", hi_q, 32'd0);
    check("R1 lo", lo_q, 32'd0);
    check("R1 busy", {31'd0, busy}, 32'd0);
    rst_n = 1'b1;

    // R8 moves
    issue(3'd5, 32'hFFFF_0000, 32'd0);
    check("R8 hi", hi_q, 32'hFFFF_0000);
    check("R8 lo kept", lo_q, 32'd0);
    issue(3'd6, 32'hFFFF_F005, 32'd0);
    check("R8 lo", lo_q, 32'hFFFF_F005);
    check("R8 hi kept", hi_q, 32'hFFFF_0000);
    // R9 idle codes
    issue(3'd0, 32'h1111_1111, 32'h2);
    check("R9 code0 hi", hi_q, 32'hFFFF_0000);
    issue(3'd7, 32'h1111_1111, 32'h2);
    check("R9 code7 lo", lo_q, 32'hFFFF_F005);
    check("R9 busy", {31'd0, busy}, 32'd0);

    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        logic [31:0] a, b;
        logic [63:0] p;
        longint sa, sb;
        a = pick(i); b = pick(j);
        sa = longint'($signed(a)); sb = longint'($signed(b));
        p = 64'(sa * sb);
        issue(3'd1, a, b);
        check("R2 hi", hi_q, p[63:32]);
        check("R2 lo", lo_q, p[31:0]);
        check("R2 busy", {31'd0, busy}, 32'd0);
        p = {32'd0, a} * {32'd0, b};
        issue(3'd2, a, b);
        check("R3 hi", hi_q, p[63:32]);
        check("R3 lo", lo_q, p[31:0]);
        issue(3'd4, a, b);
        wait_div("R6 unsigned latency");
        check("R4 lo", lo_q, (b == 0) ? 32'hFFFF_FFFF : a / b);
        check("R4 hi", hi_q, (b == 0) ? a : a % b);
        issue(3'd3, a, b);
        wait_div("R6 signed latency");
        if (b != 0) begin
          check("R5 lo", lo_q, 32'(sa / sb));
          check("R5 hi", hi_q, 32'(sa % sb));
        end
      end
    end

    // R7: move during divide ignored, registers held until result
    issue(3'd6, 32'hAAAA_5555, 32'd0);
    issue(3'd4, 32'd11, 32'd5);
    op_valid = 1'b1; op_code = 3'd5; src_a = 32'hDEAD_BEEF;
    @(negedge clk);
    op_valid = 1'b0; op_code = 3'd0;
    check("R7 hi held", hi_q, 32'h0000_0000);
    check("R7 lo held", lo_q, 32'hAAAA_5555);
    check("R7 busy", {31'd0, busy}, 32'd1);
    while (busy) @(negedge clk);
    check("R7 hi from divide", hi_q, 32'd1);
    check("R8 lo overwritten by divide", lo_q, 32'd2);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule